// File: doc/BRIEF.md
# Parallel Host Bus Slave with Prefetched Display Reads

This block is the device side of an asynchronous 8-bit parallel host bus of the read-strobe / write-strobe kind, placed in front of a display controller. The host drives active-low chip select, read and write strobes and a data/command select line. All of these pins, and the incoming data byte, are brought into the system clock through two-flop synchronizers. Completed transfers are found by comparing each synchronized strobe with its value one cycle earlier. On the controller side, a write becomes a one-cycle command strobe or data strobe carrying the byte. A read returns either the controller status byte or display memory data. The pin-level tristate buffer lies outside the block, so the bidirectional bus is split here into an input byte, an output byte and an output enable.

Display reads go through a one-deep prefetch stage. Each data read hands the host the byte already held in the read register. It then asks the memory port for the byte at the read pointer and advances the pointer. After the controller loads a new read address, the first data read therefore returns a fixed dummy byte, and later reads return consecutive addresses. A second latch style is also available. In that style the read and write strobes are held at static levels to give the direction, and the rising edge of chip select completes the transfer. The style input is taken only while chip select is inactive.

Top module: `pbus_slave`

## Requirements
- R1: After reset the bus output enable is low and no command strobe, data strobe or memory request is active.
- R2: The output enable is high only while the synchronized chip select is low, read is low and write is high. With chip select high and read low it stays low.
- R3: In strobe mode, a rising edge of the write strobe while chip select is low, with data/command low (0), gives exactly one single-cycle `cmd_valid` pulse carrying the bus byte.
- R4: The same write with data/command high (1) gives exactly one single-cycle `wr_valid` pulse carrying the bus byte, and no command pulse.
- R5: A read with data/command low drives `status_in` onto the bus and issues no memory request.
- R6: The first data read after an `addr_set` pulse returns DUMMY_BYTE (default 8'h00). An `addr_set` cancels any fetch still in flight.
- R7: The second data read after loading address n returns memory[n], and each later read returns the next address. The pointer wraps from 2^AW-1 to 0. Writes and status reads do not move the pointer.
- R8: Every data read issues exactly one single-cycle `ram_rd_req` with the current pointer on `ram_rd_addr`. The memory answers on `ram_rd_data` one clock after the request.
- R9: In chip-select latch mode (`latch_mode` = 1), a rising chip-select edge with write low and read high is a write. With read low and write high it is a read.
- R10: In strobe mode, write strobe edges while chip select is high have no effect.
- R11: A change of `latch_mode` while chip select is low takes effect only after chip select has gone high.
- R12: The command and data strobes are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_mode | input | 1 | 0 = strobe edges latch, 1 = chip-select edge latches |
| n_cs | input | 1 | Chip select, active low |
| n_rd | input | 1 | Read strobe, active low |
| n_wr | input | 1 | Write strobe, active low |
| dc | input | 1 | 0 = command/status, 1 = display data |
| bus_din | input | 8 | Byte driven by the host |
| bus_dout | output | 8 | Byte returned to the host |
| bus_oe | output | 1 | Enable for the external bus driver |
| status_in | input | 8 | Controller status byte |
| addr_set | input | 1 | Load a new read address (one cycle) |
| addr_val | input | AW | New read address |
| cmd_valid | output | 1 | Command byte strobe |
| cmd_byte | output | 8 | Command byte |
| wr_valid | output | 1 | Display data write strobe |
| wr_byte | output | 8 | Display data byte |
| ram_rd_req | output | 1 | Memory read request |
| ram_rd_addr | output | AW | Memory read address |
| ram_rd_data | input | 8 | Memory read data, one cycle after request |

## Verification
The bench aims at the prefetch corners. It reads the dummy right after an address load, where a design without the prefetch would hand back the real byte one read too early. It reads after a status read and after writes, where a pointer that moves on every transfer would skip an address. It reads across the top of the address range, where a missing wrap would fetch past the end. It toggles the write strobe with chip select high and changes the latch style while chip select is low. A design that ignores chip select would then emit spurious command strobes, and one that takes the style at any time would latch the next write by the wrong edge. Chip-select latch transfers are checked for both directions.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int BUS_W = 8;

    typedef enum logic {
        MODE_STROBE  = 1'b0,
        MODE_CSLATCH = 1'b1
    } latch_mode_e;

    // Host pins as seen after synchronization
    typedef struct packed {
        logic             n_cs;
        logic             n_rd;
        logic             n_wr;
        logic             dc;
        logic [BUS_W-1:0] data;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    localparam pins_t PINS_IDLE = '{n_cs: 1'b1, n_rd: 1'b1, n_wr: 1'b1,
                                    dc: 1'b0, data: '0};

    // One completed host transfer
    typedef struct packed {
        logic             wr;
        logic             rd;
        logic             dc;
        logic [BUS_W-1:0] data;
    } xfer_t;

    function automatic logic rose(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_cur,
    output logic [W-1:0] q_prev
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q_prev <= RST_VAL;
        else     q_prev <= chain[STAGES-1];
    end

    assign q_cur = chain[STAGES-1];

endmodule

// File: rtl/pbus_edge.sv
module pbus_edge
    import pbus_pkg::*;
(
    input  pins_t       cur,
    input  pins_t       prev,
    input  latch_mode_e mode,
    output xfer_t       xfer
);

    logic cs_rise;
    logic wr_rise;
    logic rd_rise;

    always_comb begin
        cs_rise = rose(cur.n_cs, prev.n_cs);
        wr_rise = rose(cur.n_wr, prev.n_wr);
        rd_rise = rose(cur.n_rd, prev.n_rd);

        xfer      = '0;
        xfer.dc   = prev.dc;
        xfer.data = prev.data;

        if (mode == MODE_STROBE) begin
            xfer.wr = wr_rise & ~prev.n_cs & ~cur.n_cs;
            xfer.rd = rd_rise & ~prev.n_cs & ~cur.n_cs;
        end else begin
            xfer.wr = cs_rise & ~prev.n_wr &  prev.n_rd;
            xfer.rd = cs_rise & ~prev.n_rd &  prev.n_wr;
        end
    end

endmodule

// File: rtl/pbus_rdpipe.sv
module pbus_rdpipe
    import pbus_pkg::*;
#(
    parameter int               AW         = 14,
    parameter logic [BUS_W-1:0] DUMMY_BYTE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_set,
    input  logic [AW-1:0]    addr_val,
    input  logic             data_rd,
    input  logic [BUS_W-1:0] ram_rd_data,
    output logic             ram_rd_req,
    output logic [AW-1:0]    ram_rd_addr,
    output logic [BUS_W-1:0] hold
);

    logic [AW-1:0] ptr;
    logic          pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr         <= '0;
            ram_rd_req  <= 1'b0;
            ram_rd_addr <= '0;
            pend        <= 1'b0;
            hold        <= DUMMY_BYTE;
        end else if (addr_set) begin
            ptr        <= addr_val;
            ram_rd_req <= 1'b0;
            pend       <= 1'b0;
            hold       <= DUMMY_BYTE;
        end else begin
            pend <= ram_rd_req;
            if (pend) hold <= ram_rd_data;
            if (data_rd) begin
                ram_rd_req  <= 1'b1;
                ram_rd_addr <= ptr;
                ptr         <= ptr + 1'b1;
            end else begin
                ram_rd_req  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
    import pbus_pkg::*;
#(
    parameter int               AW         = 14,
    parameter int               SYNC_DEPTH = 2,
    parameter logic [BUS_W-1:0] DUMMY_BYTE = 8'h00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch_mode,
    input  logic             n_cs,
    input  logic             n_rd,
    input  logic             n_wr,
    input  logic             dc,
    input  logic [BUS_W-1:0] bus_din,
    output logic [BUS_W-1:0] bus_dout,
    output logic             bus_oe,
    input  logic [BUS_W-1:0] status_in,
    input  logic             addr_set,
    input  logic [AW-1:0]    addr_val,
    output logic             cmd_valid,
    output logic [BUS_W-1:0] cmd_byte,
    output logic             wr_valid,
    output logic [BUS_W-1:0] wr_byte,
    output logic             ram_rd_req,
    output logic [AW-1:0]    ram_rd_addr,
    input  logic [BUS_W-1:0] ram_rd_data
);

    pins_t       pins_raw;
    pins_t       pins_cur;
    pins_t       pins_prev;
    logic [PINS_W-1:0] sync_cur;
    logic [PINS_W-1:0] sync_prev;
    latch_mode_e mode_q;
    xfer_t       xfer;
    logic [BUS_W-1:0] hold;
    logic        cs_cur;

    assign pins_raw = '{n_cs: n_cs, n_rd: n_rd, n_wr: n_wr, dc: dc, data: bus_din};

    pbus_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_DEPTH),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      (pins_raw),
        .q_cur  (sync_cur),
        .q_prev (sync_prev)
    );

    assign pins_cur  = pins_t'(sync_cur);
    assign pins_prev = pins_t'(sync_prev);
    assign cs_cur    = pins_cur.n_cs;

    // Latch style is taken only while the host is not selecting the block
    always_ff @(posedge clk) begin
        if (rst)         mode_q <= MODE_STROBE;
        else if (cs_cur) mode_q <= latch_mode_e'(latch_mode);
    end

    pbus_edge u_edge (
        .cur  (pins_cur),
        .prev (pins_prev),
        .mode (mode_q),
        .xfer (xfer)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
            wr_valid  <= 1'b0;
            wr_byte   <= '0;
        end else begin
            cmd_valid <= xfer.wr & ~xfer.dc;
            wr_valid  <= xfer.wr &  xfer.dc;
            if (xfer.wr & ~xfer.dc) cmd_byte <= xfer.data;
            if (xfer.wr &  xfer.dc) wr_byte  <= xfer.data;
        end
    end

    pbus_rdpipe #(
        .AW         (AW),
        .DUMMY_BYTE (DUMMY_BYTE)
    ) u_rdpipe (
        .clk         (clk),
        .rst         (rst),
        .addr_set    (addr_set),
        .addr_val    (addr_val),
        .data_rd     (xfer.rd & xfer.dc),
        .ram_rd_data (ram_rd_data),
        .ram_rd_req  (ram_rd_req),
        .ram_rd_addr (ram_rd_addr),
        .hold        (hold)
    );

    assign bus_oe   = ~pins_cur.n_cs & ~pins_cur.n_rd & pins_cur.n_wr;
    assign bus_dout = pins_cur.dc ? hold : status_in;

endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic wr_valid,
    input logic ram_rd_req,
    input logic addr_set,
    input logic mode_q,
    input logic cs_cur
);

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);                                   // R12
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);                                     // R12
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && wr_valid));                                   // R12
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ram_rd_req |=> !ram_rd_req);                                 // R8
    AST_SET_CANCELS: assert property (@(posedge clk) disable iff (rst)
        addr_set |=> !ram_rd_req);                                   // R6
    AST_MODE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> $past(cs_cur));                         // R11

endmodule

bind pbus_slave pbus_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .wr_valid   (wr_valid),
    .ram_rd_req (ram_rd_req),
    .addr_set   (addr_set),
    .mode_q     (mode_q),
    .cs_cur     (cs_cur)
);

// File: tb/test_pbus_slave.sv
module test_pbus_slave;

    localparam int AW = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic latch_mode = 1'b0;
    logic n_cs = 1'b1, n_rd = 1'b1, n_wr = 1'b1, dc = 1'b0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic bus_oe;
    logic [7:0] status_in = 8'h5A;
    logic addr_set = 1'b0;
    logic [AW-1:0] addr_val = '0;
    logic cmd_valid, wr_valid, ram_rd_req;
    logic [7:0] cmd_byte, wr_byte, ram_rd_data;
    logic [AW-1:0] ram_rd_addr;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    pbus_slave #(.AW(AW)) i_pbus_slave (
        .clk(clk), .rst(rst), .latch_mode(latch_mode),
        .n_cs(n_cs), .n_rd(n_rd), .n_wr(n_wr), .dc(dc),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .status_in(status_in), .addr_set(addr_set), .addr_val(addr_val),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .wr_valid(wr_valid), .wr_byte(wr_byte),
        .ram_rd_req(ram_rd_req), .ram_rd_addr(ram_rd_addr),
        .ram_rd_data(ram_rd_data)
    );

    // Memory model: byte at address a is (7a + 3) mod 256, one cycle latency
    logic [7:0] mem_q = '0;
    always_ff @(posedge clk)
        if (ram_rd_req) mem_q <= 8'((ram_rd_addr * 7) + 3);
    assign ram_rd_data = mem_q;

    // Pulse monitors
    int cmd_cnt = 0, wr_cnt = 0, req_cnt = 0;
    logic [7:0] cmd_last = '0, wr_last = '0;
    logic [AW-1:0] req_last = '0;
    always_ff @(posedge clk) begin
        if (cmd_valid)  begin cmd_cnt <= cmd_cnt + 1; cmd_last <= cmd_byte; end
        if (wr_valid)   begin wr_cnt  <= wr_cnt + 1;  wr_last  <= wr_byte;  end
        if (ram_rd_req) begin req_cnt <= req_cnt + 1; req_last <= ram_rd_addr; end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe_write(input logic d_c, input logic [7:0] b);
        n_cs = 1'b0; dc = d_c; bus_din = b; idle(4);
        n_wr = 1'b0; idle(5);
        n_wr = 1'b1; idle(5);
        n_cs = 1'b1; idle(6);
    endtask

    task automatic strobe_read(input logic d_c, output logic [7:0] b, output logic oe);
        n_cs = 1'b0; dc = d_c; idle(4);
        n_rd = 1'b0; idle(5);
        b = bus_dout; oe = bus_oe;
        n_rd = 1'b1; idle(5);
        n_cs = 1'b1; idle(6);
    endtask

    task automatic load_addr(input logic [AW-1:0] a);
        addr_val = a; addr_set = 1'b1; idle(1);
        addr_set = 1'b0; idle(3);
    endtask

    typedef enum logic [2:0] {OP_SET, OP_CMD, OP_WDAT, OP_STAT, OP_RDAT} op_e;
    typedef struct packed {
        op_e           op;
        logic [AW-1:0] arg;
        logic [7:0]    exp;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{OP_SET,  14'd10,    8'h00},
        '{OP_RDAT, 14'd0,     8'h00},   // R6 dummy
        '{OP_RDAT, 14'd0,     8'h49},   // R7 mem[10]
        '{OP_RDAT, 14'd0,     8'h50},   // R7 mem[11]
        '{OP_CMD,  14'h0A5,   8'h00},   // R3
        '{OP_WDAT, 14'h03C,   8'h00},   // R4
        '{OP_STAT, 14'd0,     8'h5A},   // R5
        '{OP_RDAT, 14'd0,     8'h57},   // R7 mem[12]
        '{OP_SET,  14'h3FFF,  8'h00},
        '{OP_RDAT, 14'd0,     8'h00},   // R6 dummy
        '{OP_RDAT, 14'd0,     8'hFC},   // R7 mem[3FFF]
        '{OP_RDAT, 14'd0,     8'h03}    // R7 wrap to mem[0]
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] b;
        logic oe;
        int c0, w0, r0;
        idle(4);
        // R1 reset state
        check("R1 oe", bus_oe, 0);
        check("R1 strobes", {cmd_valid, wr_valid, ram_rd_req}, 0);
        rst = 1'b0; idle(4);

        foreach (VECS[i]) begin
            c0 = cmd_cnt; w0 = wr_cnt; r0 = req_cnt;
            case (VECS[i].op)
                OP_SET: load_addr(VECS[i].arg);
                OP_CMD: begin
                    strobe_write(1'b0, VECS[i].arg[7:0]);
                    check("R3 count", cmd_cnt - c0, 1);
                    check("R3 byte", cmd_last, VECS[i].arg[7:0]);
                    check("R12 no data strobe", wr_cnt - w0, 0);
                end
                OP_WDAT: begin
                    strobe_write(1'b1, VECS[i].arg[7:0]);
                    check("R4 count", wr_cnt - w0, 1);
                    check("R4 byte", wr_last, VECS[i].arg[7:0]);
                    check("R4 no cmd strobe", cmd_cnt - c0, 0);
                end
                OP_STAT: begin
                    strobe_read(1'b0, b, oe);
                    check("R5 status", b, VECS[i].exp);
                    check("R2 oe on read", oe, 1);
                    check("R5 no request", req_cnt - r0, 0);
                end
                default: begin
                    strobe_read(1'b1, b, oe);
                    check("R6/R7 read data", b, VECS[i].exp);
                    check("R8 one request", req_cnt - r0, 1);
                end
            endcase
        end

        // R2: chip select high, read low -> no drive
        n_rd = 1'b0; idle(5);
        check("R2 oe with cs high", bus_oe, 0);
        n_rd = 1'b1; idle(5);

        // R10: write strobe toggled with chip select high
        c0 = cmd_cnt;
        dc = 1'b0; bus_din = 8'h77; n_wr = 1'b0; idle(5); n_wr = 1'b1; idle(6);
        check("R10 ignored write", cmd_cnt - c0, 0);

        // R11: style changed while selected stays strobe mode
        c0 = cmd_cnt;
        n_cs = 1'b0; dc = 1'b0; bus_din = 8'h21; idle(4);
        latch_mode = 1'b1; idle(3);
        n_wr = 1'b0; idle(5); n_wr = 1'b1; idle(5);
        check("R11 still strobe mode", cmd_cnt - c0, 1);
        check("R11 byte", cmd_last, 8'h21);
        n_cs = 1'b1; idle(8);

        // R9: chip-select latch write
        c0 = cmd_cnt;
        dc = 1'b0; bus_din = 8'hC3; n_wr = 1'b0; n_rd = 1'b1; idle(4);
        n_cs = 1'b0; idle(5); n_cs = 1'b1; idle(6);
        n_wr = 1'b1; idle(4);
        check("R9 cs write count", cmd_cnt - c0, 1);
        check("R9 cs write byte", cmd_last, 8'hC3);

        // R9: chip-select latch reads after new address
        load_addr(14'd4);
        for (int k = 0; k < 2; k++) begin
            dc = 1'b1; n_rd = 1'b0; n_wr = 1'b1; idle(4);
            n_cs = 1'b0; idle(5);
            b = bus_dout; oe = bus_oe;
            n_cs = 1'b1; idle(6);
            n_rd = 1'b1; idle(4);
            check("R9 cs read oe", oe, 1);
            check("R9 cs read data", b, (k == 0) ? 8'h00 : 8'h1F);
        end
        check("R8 request address", req_last, 5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule